// File: doc/BRIEF.md
# Multislope Integrating Converter Sequencer

This block is the clocked controller of an integrating converter with several slopes. It drives the switches that connect the input, the references and an integrator discharge path to an external analog integrator. It reads back a single comparator bit that is high while the integrator output is positive. A conversion is requested with `start`. The sequence has these steps:

- The input is integrated for a programmed number of cycles.
- A sign-forcing reference is applied until the integrator is known to be positive.
- A strong reference runs the integrator down past zero.
- One or two weak references climb back up to the crossing.
- Between two weak slopes, a fixed step-back returns the integrator below zero, so that every weak slope meets the crossing from below.

The switch outputs are registered, so every connection change falls on a rising clock edge, and every phase lasts a whole number of cycles. The block counts the cycles of each measured phase. It reports these counts together with a signed weighted sum that equals the input charge minus a small positive residue. An optional discharge phase follows each conversion. A phase that never sees its comparator level ends the conversion early and raises a fault flag.

Top module: `msadc_seq`

## Requirements
- R1: During and right after reset, `busy`, `done` and `fault` are 0 and every bit of `swCtl` is 0.
- R2: A `start` sampled while idle enters the run-up on that edge. Bit 0 of `swCtl` (input switch) is then on for exactly `runupLen` cycles, and after that the sign phase begins.
- R3: In the sign phase, bit 1 (sign reference) stays on for at least `signMinLen` cycles. It turns off at the first edge where that minimum is met and the synchronized comparator reads 1 (integrator positive).
- R4: The comparator passes through two flip-flops, and a phase ignores it for its first two cycles. If the level that ends a phase is first sampled at the k-th rising edge after the phase's switch turned on (k at least 1), the phase lasts exactly k+2 cycles and reports k+2.
- R5: The coarse rundown keeps bit 2 (strong opposite reference) on until the synchronized comparator reads 0. Its duration is reported on `coarseCount`.
- R6: Fine slope j drives bit 4+j and ends when the synchronized comparator reads 1. Between fine slope j and j+1, bit 2 is on for exactly `BACK_CYC` cycles. Fine counts appear on `fineCount`, slope j in bits [16j+15:16j].
- R7: `done` is a one-cycle pulse after the last fine slope. While it is high, `result` equals W_COARSE*(coarse + BACK_CYC*(NUM_FINE-1)) - W_SIGN*sign - sum of W_FINEj*finej. For an ideal integrator, input times run-up length minus `result` lies between 0 and 8 when W_FINE1 is 1.
- R8: If a sign, coarse or fine phase reaches `timeoutLen` cycles without its ending level, that phase reports `timeoutLen`, later counts read 0, and `done` pulses with `fault` high. `fault` stays high until the next start.
- R9: After `done`, bit 3 (integrator discharge) is on for exactly `resetLen` cycles, or is skipped when `resetLen` is 0. `busy` stays high until that phase ends.
- R10: `start` has no effect while `busy` is high. Once idle, `busy` stays low and no switch turns on until a new start.
- R11: At most one bit of `swCtl` is ever on, and all bits are off in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | conversion request, taken only while idle |
| compIn | input | 1 | asynchronous comparator bit, 1 = integrator positive |
| runupLen | input | CNT_W | run-up length in cycles |
| signMinLen | input | CNT_W | minimum sign-phase length in cycles |
| timeoutLen | input | CNT_W | per-phase abort limit in cycles |
| resetLen | input | CNT_W | discharge phase length, 0 skips it |
| swCtl | output | 4+NUM_FINE | switch enables: 0 input, 1 sign ref, 2 coarse ref, 3 discharge, 4+j fine j |
| busy | output | 1 | conversion or discharge in progress |
| done | output | 1 | one-cycle end-of-conversion pulse |
| fault | output | 1 | last conversion aborted on timeout |
| signCount | output | CNT_W | sign phase cycles |
| coarseCount | output | CNT_W | coarse rundown cycles |
| fineCount | output | NUM_FINE*CNT_W | packed fine slope cycles |
| result | output | RES_W | signed weighted sum of the counts |

## Verification
Scripted comparator edges placed a known number of cycles into each phase separate a correct two-edge synchronizer latency from an off-by-one in the counters or the blanking. A comparator that is already high before the sign phase isolates the minimum-length rule. A comparator that never falls exposes the timeout and fault path, and it also carries a start pulse issued mid-conversion. A behavioral integrator driven with a positive and a negative input shows that both polarities leave the same small positive residue after the weighted sum.

// File: rtl/msadc_pkg.sv
package msadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUNUP,
    ST_SIGN,
    ST_COARSE,
    ST_FINE,
    ST_BACK,
    ST_DONE,
    ST_RST
  } seqState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic clrAll;
    logic clrPhase;
    logic capSign;
    logic capCoarse;
    logic capFine;
    logic fineSel;
    logic setFault;
  } dpStrobe_t;

  // compare results from the datapath to the control
  typedef struct packed {
    logic runupEnd;
    logic minMet;
    logic blankOver;
    logic timeUp;
    logic backEnd;
    logic rstEnd;
    logic rstSkip;
  } dpFlags_t;

  localparam int SW_INPUT  = 0;
  localparam int SW_SIGN   = 1;
  localparam int SW_COARSE = 2;
  localparam int SW_RESET  = 3;
  localparam int SW_FINE0  = 4;

endpackage

// File: rtl/msadc_sync.sv
module msadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], asyncIn};
  end

  assign syncOut = stg[STAGES-1];
endmodule

// File: rtl/msadc_ctrl.sv
module msadc_ctrl
  import msadc_pkg::*;
#(
  parameter int NUM_FINE = 2,
  localparam int NSW = SW_FINE0 + NUM_FINE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           compSync,
  input  dpFlags_t       flags,
  output dpStrobe_t      stb,
  output logic [NSW-1:0] swCtl,
  output logic           busy,
  output logic           done
);
  localparam logic LAST_FINE = 1'(NUM_FINE - 1);

  seqState_t state, nxtState;
  logic      fineIdx, nxtFine;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fineIdx <= 1'b0;
    end else begin
      state   <= nxtState;
      fineIdx <= nxtFine;
    end
  end

  always_comb begin
    nxtState    = state;
    nxtFine     = fineIdx;
    stb         = '0;
    stb.fineSel = fineIdx;
    unique case (state)
      ST_IDLE: if (start) begin
        nxtState     = ST_RUNUP;
        stb.clrAll   = 1'b1;
        stb.clrPhase = 1'b1;
      end
      ST_RUNUP: if (flags.runupEnd) begin
        nxtState     = ST_SIGN;
        stb.clrPhase = 1'b1;
      end
      ST_SIGN: begin
        if (flags.blankOver && flags.minMet && compSync) begin
          nxtState     = ST_COARSE;
          stb.capSign  = 1'b1;
          stb.clrPhase = 1'b1;
        end else if (flags.timeUp) begin
          nxtState     = ST_DONE;
          stb.capSign  = 1'b1;
          stb.setFault = 1'b1;
        end
      end
      ST_COARSE: begin
        if (flags.blankOver && !compSync) begin
          nxtState      = ST_FINE;
          nxtFine       = 1'b0;
          stb.capCoarse = 1'b1;
          stb.clrPhase  = 1'b1;
        end else if (flags.timeUp) begin
          nxtState      = ST_DONE;
          stb.capCoarse = 1'b1;
          stb.setFault  = 1'b1;
        end
      end
      ST_FINE: begin
        if (flags.blankOver && compSync) begin
          stb.capFine  = 1'b1;
          stb.clrPhase = 1'b1;
          nxtState     = (fineIdx == LAST_FINE) ? ST_DONE : ST_BACK;
        end else if (flags.timeUp) begin
          nxtState     = ST_DONE;
          stb.capFine  = 1'b1;
          stb.setFault = 1'b1;
        end
      end
      ST_BACK: if (flags.backEnd) begin
        nxtState     = ST_FINE;
        nxtFine      = fineIdx + 1'b1;
        stb.clrPhase = 1'b1;
      end
      ST_DONE: begin
        stb.clrPhase = 1'b1;
        nxtState     = flags.rstSkip ? ST_IDLE : ST_RST;
      end
      ST_RST: if (flags.rstEnd) nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  // switch decode straight from the state register
  assign swCtl[SW_INPUT]  = (state == ST_RUNUP);
  assign swCtl[SW_SIGN]   = (state == ST_SIGN);
  assign swCtl[SW_COARSE] = (state == ST_COARSE) || (state == ST_BACK);
  assign swCtl[SW_RESET]  = (state == ST_RST);

  for (genvar g = 0; g < NUM_FINE; g++) begin : g_fineSw
    assign swCtl[SW_FINE0 + g] = (state == ST_FINE) && (fineIdx == 1'(g));
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/msadc_dp.sv
module msadc_dp
  import msadc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_FINE    = 2,
  parameter int RES_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int BACK_CYC    = 1,
  parameter int W_SIGN      = 256,
  parameter int W_COARSE    = 256,
  parameter int W_FINE0     = 16,
  parameter int W_FINE1     = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  dpStrobe_t                 stb,
  input  logic [CNT_W-1:0]          runupLen,
  input  logic [CNT_W-1:0]          signMinLen,
  input  logic [CNT_W-1:0]          timeoutLen,
  input  logic [CNT_W-1:0]          resetLen,
  output dpFlags_t                  flags,
  output logic                      fault,
  output logic [CNT_W-1:0]          signCount,
  output logic [CNT_W-1:0]          coarseCount,
  output logic [NUM_FINE*CNT_W-1:0] fineCount,
  output logic signed [RES_W-1:0]   result
);
  localparam int EXT_W = CNT_W + 1;
  localparam logic signed [RES_W-1:0] WS = RES_W'(W_SIGN);
  localparam logic signed [RES_W-1:0] WC = RES_W'(W_COARSE);
  localparam logic signed [RES_W-1:0] BACK_CHG = RES_W'(W_COARSE * BACK_CYC * (NUM_FINE - 1));
  localparam logic signed [RES_W-1:0] WF [2] = '{RES_W'(W_FINE0), RES_W'(W_FINE1)};

  logic [CNT_W-1:0] phaseCnt;
  logic [EXT_W-1:0] elapsed;
  logic [CNT_W-1:0] capVal;
  logic [CNT_W-1:0] signQ, coarseQ;
  logic [CNT_W-1:0] fineQ [NUM_FINE];
  logic             faultQ;

  assign elapsed = {1'b0, phaseCnt} + EXT_W'(1);
  assign capVal  = elapsed[CNT_W] ? '1 : elapsed[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phaseCnt <= '0;
    else if (stb.clrPhase)     phaseCnt <= '0;
    else if (phaseCnt != '1)   phaseCnt <= phaseCnt + 1'b1;
  end

  assign flags.runupEnd  = elapsed >= {1'b0, runupLen};
  assign flags.minMet    = elapsed >= {1'b0, signMinLen};
  assign flags.timeUp    = elapsed >= {1'b0, timeoutLen};
  assign flags.backEnd   = elapsed >= EXT_W'(BACK_CYC);
  assign flags.rstEnd    = elapsed >= {1'b0, resetLen};
  assign flags.rstSkip   = (resetLen == '0);
  assign flags.blankOver = phaseCnt >= CNT_W'(SYNC_STAGES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      signQ   <= '0;
      coarseQ <= '0;
      faultQ  <= 1'b0;
      for (int i = 0; i < NUM_FINE; i++) fineQ[i] <= '0;
    end else if (stb.clrAll) begin
      signQ   <= '0;
      coarseQ <= '0;
      faultQ  <= 1'b0;
      for (int i = 0; i < NUM_FINE; i++) fineQ[i] <= '0;
    end else begin
      if (stb.capSign)   signQ   <= capVal;
      if (stb.capCoarse) coarseQ <= capVal;
      if (stb.setFault)  faultQ  <= 1'b1;
      for (int i = 0; i < NUM_FINE; i++)
        if (stb.capFine && (stb.fineSel == 1'(i))) fineQ[i] <= capVal;
    end
  end

  function automatic logic signed [RES_W-1:0] widen(input logic [CNT_W-1:0] v);
    return $signed(RES_W'(v));
  endfunction

  always_comb begin
    result = WC * widen(coarseQ) + BACK_CHG - WS * widen(signQ);
    for (int i = 0; i < NUM_FINE; i++) result = result - WF[i] * widen(fineQ[i]);
  end

  for (genvar g = 0; g < NUM_FINE; g++) begin : g_finePack
    assign fineCount[g*CNT_W +: CNT_W] = fineQ[g];
  end

  assign signCount   = signQ;
  assign coarseCount = coarseQ;
  assign fault       = faultQ;
endmodule

// File: rtl/msadc_seq.sv
module msadc_seq
  import msadc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_FINE    = 2,
  parameter int RES_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int BACK_CYC    = 1,
  parameter int W_SIGN      = 256,
  parameter int W_COARSE    = 256,
  parameter int W_FINE0     = 16,
  parameter int W_FINE1     = 1,
  localparam int NSW = SW_FINE0 + NUM_FINE
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      compIn,
  input  logic [CNT_W-1:0]          runupLen,
  input  logic [CNT_W-1:0]          signMinLen,
  input  logic [CNT_W-1:0]          timeoutLen,
  input  logic [CNT_W-1:0]          resetLen,
  output logic [NSW-1:0]            swCtl,
  output logic                      busy,
  output logic                      done,
  output logic                      fault,
  output logic [CNT_W-1:0]          signCount,
  output logic [CNT_W-1:0]          coarseCount,
  output logic [NUM_FINE*CNT_W-1:0] fineCount,
  output logic signed [RES_W-1:0]   result
);
  logic      compSync;
  dpStrobe_t stb;
  dpFlags_t  flags;

  msadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn (compIn),
    .syncOut (compSync)
  );

  msadc_ctrl #(.NUM_FINE(NUM_FINE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .compSync (compSync),
    .flags    (flags),
    .stb      (stb),
    .swCtl    (swCtl),
    .busy     (busy),
    .done     (done)
  );

  msadc_dp #(
    .CNT_W(CNT_W), .NUM_FINE(NUM_FINE), .RES_W(RES_W), .SYNC_STAGES(SYNC_STAGES),
    .BACK_CYC(BACK_CYC), .W_SIGN(W_SIGN), .W_COARSE(W_COARSE),
    .W_FINE0(W_FINE0), .W_FINE1(W_FINE1)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .runupLen    (runupLen),
    .signMinLen  (signMinLen),
    .timeoutLen  (timeoutLen),
    .resetLen    (resetLen),
    .flags       (flags),
    .fault       (fault),
    .signCount   (signCount),
    .coarseCount (coarseCount),
    .fineCount   (fineCount),
    .result      (result)
  );
endmodule

// File: rtl/msadc_chk.sv
module msadc_chk #(
  parameter int NSW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           fault,
  input logic [NSW-1:0] swCtl
);
  // R11
  swctl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(swCtl));

  // R11
  done_swoff_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (swCtl == '0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> !busy);

  // R8
  fault_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(fault) |-> done);

  // R2
  runup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(swCtl[0]) |-> $past(!busy));
endmodule

bind msadc_seq msadc_chk #(.NSW(NSW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .fault (fault),
  .swCtl (swCtl)
);

// File: tb/msadc_seq_tb.sv
`timescale 1ns/1ps
module msadc_seq_tb;
  localparam int CNT_W = 16, NUM_FINE = 2, RES_W = 32, BACK_CYC = 1;
  localparam int W_SIGN = 256, W_COARSE = 256, W_FINE0 = 16, W_FINE1 = 1;
  localparam int NSW = 4 + NUM_FINE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scriptComp = 1'b0, modelComp = 1'b0, useModel = 1'b0;
  logic compIn;
  logic [CNT_W-1:0] runupLen = 16'd30, signMinLen = 16'd2, timeoutLen = 16'd1000, resetLen = 16'd5;
  logic [NSW-1:0] swCtl;
  logic busy, done, fault;
  logic [CNT_W-1:0] signCount, coarseCount;
  logic [NUM_FINE*CNT_W-1:0] fineCount;
  logic signed [RES_W-1:0] result;

  assign compIn = useModel ? modelComp : scriptComp;

  always #2.5 clk = ~clk;

  msadc_seq #(
    .CNT_W(CNT_W), .NUM_FINE(NUM_FINE), .RES_W(RES_W), .BACK_CYC(BACK_CYC),
    .W_SIGN(W_SIGN), .W_COARSE(W_COARSE), .W_FINE0(W_FINE0), .W_FINE1(W_FINE1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .compIn(compIn),
    .runupLen(runupLen), .signMinLen(signMinLen), .timeoutLen(timeoutLen), .resetLen(resetLen),
    .swCtl(swCtl), .busy(busy), .done(done), .fault(fault),
    .signCount(signCount), .coarseCount(coarseCount), .fineCount(fineCount), .result(result)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct {
    int     sign;
    int     coarse;
    int     f0;
    int     f1;
    bit     fault;
    bit     exact;
    longint vinN;
    int     runup;
  } exp_t;

  exp_t   expQ[$];
  longint integ = 0;
  longint vin = 0;
  int     runCyc = 0;
  bit     ohBad = 1'b0;

  // integrator model, run-up tally and scoreboard monitor
  always @(negedge clk) begin
    if (useModel) begin
      if (swCtl[3]) integ = 0;
      else integ = integ + (swCtl[0] ? vin : 0) + (swCtl[1] ? W_SIGN : 0)
                         - (swCtl[2] ? W_COARSE : 0) + (swCtl[4] ? W_FINE0 : 0)
                         + (swCtl[5] ? W_FINE1 : 0);
      modelComp = (integ > 0);
    end
    if (swCtl[0]) runCyc++;
    if (!$onehot0(swCtl)) ohBad = 1'b1;
    if (done) begin
      if (expQ.size() == 0) chk(1'b0, "R7 done with no pending item", 1, 0);
      else begin
        exp_t e;
        longint expRes, act;
        e = expQ.pop_front();
        act = longint'(result);
        chk(runCyc == e.runup, "R2 run-up cycles", runCyc, e.runup);
        chk(swCtl == '0, "R11 switches off at done", swCtl, 0);
        chk(fault == e.fault, "R8 fault flag", fault, e.fault);
        if (e.exact) begin
          chk(signCount == e.sign, "R3/R4 sign count", signCount, e.sign);
          chk(coarseCount == e.coarse, "R5 coarse count", coarseCount, e.coarse);
          chk(fineCount[15:0] == e.f0, "R6 fine0 count", fineCount[15:0], e.f0);
          chk(fineCount[31:16] == e.f1, "R6 fine1 count", fineCount[31:16], e.f1);
          if (!e.fault) begin
            expRes = W_COARSE * (e.coarse + BACK_CYC) - W_SIGN * e.sign
                   - W_FINE0 * e.f0 - W_FINE1 * e.f1;
            chk(act == expRes, "R7 weighted result", act, expRes);
          end
        end else begin
          chk((e.vinN - act >= 0) && (e.vinN - act <= 8), "R7 residue of model conversion",
              act, e.vinN);
        end
      end
      runCyc = 0;
    end
  end

  task automatic doStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitBit(input int b);
    do @(negedge clk); while (!swCtl[b]);
  endtask

  task automatic tripAfter(input int b, input int k, input logic lvl);
    waitBit(b);
    repeat (k - 1) @(negedge clk);
    scriptComp = lvl;
  endtask

  // waits for done, then measures the discharge phase until idle (R9)
  task automatic waitIdle(input int expRst);
    int n = 0;
    do @(negedge clk); while (!done);
    do begin
      @(negedge clk);
      if (swCtl[3]) n++;
    end while (busy);
    chk(n == expRst, "R9 discharge cycles", n, expRst);
  endtask

  task automatic pushItem(input int s, input int c, input int a, input int b, input bit f,
                          input bit ex, input longint vn, input int ru);
    exp_t e;
    e.sign = s; e.coarse = c; e.f0 = a; e.f1 = b; e.fault = f;
    e.exact = ex; e.vinN = vn; e.runup = ru;
    expQ.push_back(e);
  endtask

  task automatic runModel(input longint v, input int ru);
    runupLen = CNT_W'(ru); signMinLen = 16'd4; timeoutLen = 16'd3000; resetLen = 16'd4;
    integ = 0; vin = v; modelComp = 1'b0; useModel = 1'b1;
    pushItem(0, 0, 0, 0, 1'b0, 1'b0, v * ru, ru);
    doStart();
    waitIdle(4);
    useModel = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired, run hung");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && swCtl == '0, "R1 state during reset", {busy, done, fault}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && swCtl == '0, "R1 state after reset", swCtl, 0);

    // scripted edges: counts are k+2 per phase (R4)
    scriptComp = 1'b0;
    pushItem(7, 12, 6, 9, 1'b0, 1'b1, 0, 30);
    doStart();
    tripAfter(1, 5, 1'b1);
    tripAfter(2, 10, 1'b0);
    tripAfter(4, 4, 1'b1);
    tripAfter(2, 1, 1'b0);
    tripAfter(5, 7, 1'b1);
    waitIdle(5);

    // comparator already high: sign phase held to its minimum (R3)
    scriptComp = 1'b1; signMinLen = 16'd20; resetLen = 16'd0;
    pushItem(20, 5, 4, 3, 1'b0, 1'b1, 0, 30);
    doStart();
    tripAfter(2, 3, 1'b0);
    tripAfter(4, 2, 1'b1);
    tripAfter(2, 1, 1'b0);
    tripAfter(5, 1, 1'b1);
    waitIdle(0);

    // coarse never trips: timeout and fault (R8); start mid-run ignored (R10)
    scriptComp = 1'b1; signMinLen = 16'd2; timeoutLen = 16'd50; resetLen = 16'd3;
    pushItem(3, 50, 0, 0, 1'b1, 1'b1, 0, 30);
    doStart();
    waitBit(2);
    repeat (5) @(negedge clk);
    doStart();
    waitIdle(3);
    repeat (10) @(negedge clk);
    chk(!busy && swCtl == '0, "R10 start during busy ignored", busy, 0);
    chk(fault, "R8 fault held while idle", fault, 1);

    // behavioral integrator, both input polarities (R7)
    runModel(50, 100);
    runModel(-70, 80);

    chk(!ohBad, "R11 switch one-hot over run", ohBad, 0);
    chk(expQ.size() == 0, "R7 all conversions completed", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule